// File: doc/BRIEF.md
# Change-of-State Input Interrupt Controller

This block samples a 32-bit bank of digital inputs and raises a level interrupt when a configured change-of-state condition on the low 16 inputs is satisfied. Software programs two per-channel selection masks and a control word over a small 32-bit register bus. The control word enables the logic and picks one of two combining modes. In edge mode, any selected channel that shows its chosen transition causes an event. In level mode, an event needs every selected channel to sit at its chosen level at the same moment.

Each event records the channels that caused it in a sticky status register. The interrupt line stays high while that register is non-zero and the logic is enabled. A read of the status register returns the recorded channels and clears them. The live input register always shows all 32 synchronised inputs. The upper 16 inputs never take part in event detection.

Software can pause event generation by writing zero to the control register and can restore it by writing the saved word back. The masks are kept through the pause.

Top module: `cos_irq_ctrl`

## Requirements
- R1: A read with bus_addr 0x00 returns all 32 inputs after the input synchroniser (two flip-flop stages). A change on din appears in bus_rdata after the second rising clock edge.
- R2: din[31:16] never produce an event and never set a status bit, whatever the masks and mode.
- R3: Edge mode is control bit 1 = 1 with enable bit 2 = 1. In this mode, a 0-to-1 transition of synchronised input i, where i is set in the high mask (offset 0x04), sets status bit i and raises irq. Status is latched on the third rising edge after the din change.
- R4: In edge mode, a 1-to-0 transition of input i, where i is set in the low mask (offset 0x08), sets status bit i. A channel set in both masks reacts to both transitions.
- R5: Level mode is control bit 1 = 0 with bit 2 = 1. The selected channels are those set in exactly one mask. An event fires when there is at least one selected channel and each one is at its level: high for the high mask, low for the low mask. The event sets the status bits of all selected channels. A channel set in both masks is ignored.
- R6: After a level-mode event, no further event fires while the condition stays met. The condition must first become false and then hold again.
- R7: A read with bus_addr 0x0C returns the status in bits 15:0 (upper bits zero) and clears it on that clock edge, which drops irq. An event detected in the same cycle as the clearing read is kept.
- R8: Events that arrive while status is non-zero are ORed into it. Earlier bits are never lost before a read.
- R9: The control register at 0x10 holds enable in bit 2 and mode in bit 1 and reads pending (status non-zero) in bit 0. While enable is 0, no event is generated and irq is low. Masks and status are retained, and writing the earlier word back resumes detection.
- R10: After reset, every register reads zero and irq is low.
- R11: The masks read back at 0x04 and 0x08 as their 16 stored bits, with bits 31:16 reading zero. Writes to 0x00 and 0x0C change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 32 | Asynchronous digital inputs |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (status read clears) |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
Edge mode is driven with single-channel rising and falling steps, with a channel set in both masks, and with toggles on the upper 16 inputs only. These patterns separate edge polarity selection and show that the upper half is excluded. Level mode is driven with a pattern that reaches the full condition while a both-mask channel and an unselected channel toggle. The pattern then leaves the condition and returns to it, which separates a one-shot event from one that repeats while matched. A long stretch of random input words under each mode, with interleaved status reads, is compared against a behavioural reference every cycle. This covers events that merge while pending and events that collide with a clearing read.

// File: rtl/cos_pkg.sv
package cos_pkg;
   typedef enum logic [2:0] {
      RIX_LIVE  = 3'd0,
      RIX_HMASK = 3'd1,
      RIX_LMASK = 3'd2,
      RIX_STAT  = 3'd3,
      RIX_CTRL  = 3'd4
   } reg_idx_e;

   localparam int CTRL_PEND_BIT = 0;
   localparam int CTRL_MODE_BIT = 1;
   localparam int CTRL_EN_BIT   = 2;
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] q_prev
);
   logic [W-1:0] stg [STAGES+1];

   always_ff @(posedge clk) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   for (genvar s = 1; s <= STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) stg[s] <= '0;
         else        stg[s] <= stg[s-1];
      end
   end

   assign q      = stg[STAGES-1];
   assign q_prev = stg[STAGES];
endmodule

// File: rtl/cos_detect.sv
module cos_detect #(
   parameter int N = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] cur,
   input  logic [N-1:0] prv,
   input  logic [N-1:0] hmask,
   input  logic [N-1:0] lmask,
   input  logic         en,
   input  logic         or_mode,
   output logic [N-1:0] ev,
   output logic         match
);
   logic [N-1:0] edge_hit;
   logic [N-1:0] hreq, lreq, sel;
   logic         hold, fire;

   for (genvar i = 0; i < N; i++) begin : g_chan
      assign edge_hit[i] = (cur[i] & ~prv[i] & hmask[i]) |
                           (~cur[i] & prv[i] & lmask[i]);
   end

   assign hreq  = hmask & ~lmask;
   assign lreq  = lmask & ~hmask;
   assign sel   = hreq | lreq;
   assign match = (sel != '0) && ((cur & hreq) == hreq) && ((~cur & lreq) == lreq);
   assign fire  = en && !or_mode && match && !hold;

   always_ff @(posedge clk) begin
      if (!rst_n) hold <= 1'b0;
      else        hold <= en && !or_mode && match;
   end

   always_comb begin
      ev = '0;
      if (en) begin
         if (or_mode)   ev = edge_hit;
         else if (fire) ev = sel;
      end
   end
endmodule

// File: rtl/cos_status.sv
module cos_status #(
   parameter int N = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] ev,
   input  logic         clr,
   output logic [N-1:0] status,
   output logic         pending
);
   always_ff @(posedge clk) begin
      if (!rst_n) status <= '0;
      else        status <= (clr ? '0 : status) | ev;
   end

   assign pending = |status;
endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl #(
   parameter int DW          = 32,
   parameter int NCOS        = 16,
   parameter int ADDR_W      = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DW-1:0]     din,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   output logic              irq
);
   import cos_pkg::*;

   localparam int IDX_W = ADDR_W - 2;

   if (NCOS < 1 || NCOS > DW) begin : g_bad_ncos
      $error("NCOS must be between 1 and DW");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W must hold five registers of four bytes");
   end
   if (DW < 3) begin : g_bad_dw
      $error("DW must hold the control bits");
   end

   logic [DW-1:0]   in_now, in_prev;
   logic [NCOS-1:0] hmask, lmask, ev, status;
   logic            ctrl_en, ctrl_or, pending, stat_clr, match;
   logic [IDX_W-1:0] idx;

   assign idx = bus_addr[ADDR_W-1:2];

   cos_sync #(.W(DW), .STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(din), .q(in_now), .q_prev(in_prev)
   );

   cos_detect #(.N(NCOS)) det_i (
      .clk(clk), .rst_n(rst_n),
      .cur(in_now[NCOS-1:0]), .prv(in_prev[NCOS-1:0]),
      .hmask(hmask), .lmask(lmask), .en(ctrl_en), .or_mode(ctrl_or),
      .ev(ev), .match(match)
   );

   assign stat_clr = bus_rd && (idx == IDX_W'(RIX_STAT));

   cos_status #(.N(NCOS)) stat_i (
      .clk(clk), .rst_n(rst_n), .ev(ev), .clr(stat_clr),
      .status(status), .pending(pending)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hmask   <= '0;
         lmask   <= '0;
         ctrl_en <= 1'b0;
         ctrl_or <= 1'b0;
      end else if (bus_wr) begin
         if (idx == IDX_W'(RIX_HMASK)) hmask <= bus_wdata[NCOS-1:0];
         if (idx == IDX_W'(RIX_LMASK)) lmask <= bus_wdata[NCOS-1:0];
         if (idx == IDX_W'(RIX_CTRL)) begin
            ctrl_en <= bus_wdata[CTRL_EN_BIT];
            ctrl_or <= bus_wdata[CTRL_MODE_BIT];
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (idx == IDX_W'(RIX_LIVE))  bus_rdata = in_now;
      if (idx == IDX_W'(RIX_HMASK)) bus_rdata[NCOS-1:0] = hmask;
      if (idx == IDX_W'(RIX_LMASK)) bus_rdata[NCOS-1:0] = lmask;
      if (idx == IDX_W'(RIX_STAT))  bus_rdata[NCOS-1:0] = status;
      if (idx == IDX_W'(RIX_CTRL)) begin
         bus_rdata[CTRL_EN_BIT]   = ctrl_en;
         bus_rdata[CTRL_MODE_BIT] = ctrl_or;
         bus_rdata[CTRL_PEND_BIT] = pending;
      end
   end

   assign irq = ctrl_en && pending;

   logic unused_bits;
   assign unused_bits = ^{bus_wdata, bus_addr[1:0], in_prev};
endmodule

// File: rtl/cos_irq_ctrl_chk.sv
module cos_irq_ctrl_chk #(
   parameter int N = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         irq,
   input logic         en,
   input logic         or_mode,
   input logic [N-1:0] ev,
   input logic [N-1:0] status,
   input logic         stat_clr,
   input logic         match
);
   assert_irq_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (status != '0 && en));

   assert_clear_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr && ev == '0) |=> (status == '0));

   assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_clr |=> ((status & $past(status)) == $past(status)));

   assert_quiet_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (ev == '0));

   assert_level_needs_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !or_mode && ev != '0) |-> match);

   assert_level_single_shot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ev != '0 && !or_mode) |=> (ev == '0 || or_mode));
endmodule

bind cos_irq_ctrl cos_irq_ctrl_chk #(.N(NCOS)) chk_i (
   .clk(clk), .rst_n(rst_n), .irq(irq), .en(ctrl_en), .or_mode(ctrl_or),
   .ev(ev), .status(status), .stat_clr(stat_clr), .match(match)
);

// File: tb/cos_irq_ctrl_tb_top.sv
`timescale 1ns/100ps
module cos_irq_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] din = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int n_chk = 0, n_bad = 0;
   string cur_req = "R10";
   bit done = 1'b0;

   always #2 clk = ~clk;

   cos_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .din(din), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   // behavioural reference
   logic [31:0] h1 = '0, h2 = '0, h3 = '0;
   logic [15:0] m_hi = '0, m_lo = '0, m_st = '0;
   bit m_en = 0, m_or = 0, m_hold = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         h1 = '0; h2 = '0; h3 = '0; m_hi = '0; m_lo = '0; m_st = '0;
         m_en = 0; m_or = 0; m_hold = 0;
      end else begin
         logic [15:0] evm, hreq, lreq, act;
         bit mt;
         evm = '0;
         hreq = m_hi & ~m_lo; lreq = m_lo & ~m_hi; act = hreq | lreq;
         mt = (act != 0) && ((h2[15:0] & hreq) == hreq) && ((~h2[15:0] & lreq) == lreq);
         if (m_en && m_or) begin
            for (int i = 0; i < 16; i++)
               if ((h2[i] && !h3[i] && m_hi[i]) || (!h2[i] && h3[i] && m_lo[i])) evm[i] = 1'b1;
         end else if (m_en && mt && !m_hold) evm = act;
         m_hold = m_en && !m_or && mt;
         if (bus_rd && bus_addr[4:2] == 3'd3) m_st = '0;
         m_st = m_st | evm;
         if (bus_wr) begin
            if (bus_addr[4:2] == 3'd1) m_hi = bus_wdata[15:0];
            if (bus_addr[4:2] == 3'd2) m_lo = bus_wdata[15:0];
            if (bus_addr[4:2] == 3'd4) begin m_en = bus_wdata[2]; m_or = bus_wdata[1]; end
         end
         h3 = h2; h2 = h1; h1 = din;
      end
   end

   function automatic logic [31:0] model_read(input logic [4:0] a);
      case (a[4:2])
         3'd0: return h2;
         3'd1: return {16'h0, m_hi};
         3'd2: return {16'h0, m_lo};
         3'd3: return {16'h0, m_st};
         3'd4: return {29'h0, m_en, m_or, (m_st != 0)};
         default: return 32'h0;
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the reference
   initial begin
      forever begin
         @(negedge clk); #0.5;
         if (rst_n) begin
            check(cur_req, {31'h0, irq}, {31'h0, (m_en && m_st != 0)});
            check(cur_req, bus_rdata, model_read(bus_addr));
         end
      end
   end

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0; bus_addr = 5'h1C;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk); bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk); bus_rd = 1'b0; bus_addr = 5'h1C;
   endtask

   task automatic set_din(input logic [31:0] v);
      @(negedge clk); din = v;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      bus_addr = 5'h1C;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10: reset state
      cur_req = "R10";
      for (int a = 0; a < 5; a++) begin
         rd(5'(a * 4), v); check("R10", v, 32'h0);
      end
      check("R10", {31'h0, irq}, 32'h0);

      // R1: live inputs, all 32 bits
      cur_req = "R1";
      set_din(32'hA5C3_1234);
      @(posedge clk); @(posedge clk); #1;
      bus_addr = 5'h00; #0.5;
      check("R1", bus_rdata, 32'hA5C3_1234);
      idle(1);

      // R11: mask readback, writes to read-only offsets ignored
      cur_req = "R11";
      wr(5'h04, 32'hFFFF_00F0); rd(5'h04, v); check("R11", v, 32'h0000_00F0);
      wr(5'h08, 32'h1234_0F0F); rd(5'h08, v); check("R11", v, 32'h0000_0F0F);
      wr(5'h00, 32'hFFFF_FFFF); wr(5'h0C, 32'hFFFF_FFFF);
      rd(5'h0C, v); check("R11", v, 32'h0);
      rd(5'h00, v); check("R11", v, 32'hA5C3_1234);

      // R3: rising edge in edge mode
      cur_req = "R3";
      set_din(32'h0);
      wr(5'h04, 32'h0000_0003); wr(5'h08, 32'h0);
      idle(4); rd(5'h0C, v);
      wr(5'h10, 32'h6);
      set_din(32'h0000_0001);
      idle(4);
      check("R3", {31'h0, irq}, 32'h1);
      rd(5'h10, v); check("R3", v, 32'h7);
      rd(5'h0C, v); check("R3", v, 32'h0000_0001);
      check("R3", {31'h0, irq}, 32'h0);

      // R4: falling edge, and a channel in both masks
      cur_req = "R4";
      wr(5'h04, 32'h0000_0004); wr(5'h08, 32'h0000_0005);
      set_din(32'h0000_0004); idle(4);
      rd(5'h0C, v); check("R4", v, 32'h0000_0005);
      set_din(32'h0000_0000); idle(4);
      rd(5'h0C, v); check("R4", v, 32'h0000_0004);

      // R8: events accumulate while pending
      cur_req = "R8";
      set_din(32'h0000_0004); idle(4);
      set_din(32'h0000_0005); idle(4);
      rd(5'h0C, v); check("R8", v, 32'h0000_0004);
      set_din(32'h0000_0004); idle(4);
      set_din(32'h0000_0000); idle(4);
      rd(5'h0C, v); check("R8", v, 32'h0000_0005);

      // R2: upper inputs never cause events
      cur_req = "R2";
      wr(5'h04, 32'hFFFF_FFFF); wr(5'h08, 32'hFFFF_FFFF);
      rd(5'h0C, v);
      for (int k = 0; k < 6; k++) begin
         set_din({16'(k * 16'h3A5B + 16'h1), 16'h0}); idle(3);
      end
      idle(3);
      check("R2", {31'h0, irq}, 32'h0);
      rd(5'h0C, v); check("R2", v, 32'h0);

      // R5: level mode condition; channel 5 in both masks
      cur_req = "R5";
      wr(5'h10, 32'h0);
      wr(5'h04, 32'h0000_0031); wr(5'h08, 32'h0000_0120);
      set_din(32'h0000_0031); idle(4);
      rd(5'h0C, v);
      wr(5'h10, 32'h4);
      idle(3);
      check("R5", {31'h0, irq}, 32'h1);
      rd(5'h0C, v); check("R5", v, 32'h0000_0111);

      // R6: no re-fire while matched; leave and re-enter
      cur_req = "R6";
      set_din(32'h0000_0211); idle(4);
      set_din(32'h0000_0031); idle(4);
      check("R6", {31'h0, irq}, 32'h0);
      rd(5'h0C, v); check("R6", v, 32'h0);
      set_din(32'h0000_0030); idle(4);
      check("R6", {31'h0, irq}, 32'h0);
      set_din(32'h0000_0011); idle(4);
      check("R6", {31'h0, irq}, 32'h1);
      rd(5'h0C, v); check("R6", v, 32'h0000_0111);

      // R9: pause and resume
      cur_req = "R9";
      wr(5'h10, 32'h0);
      set_din(32'h0000_0010); idle(4);
      set_din(32'h0000_0011); idle(4);
      check("R9", {31'h0, irq}, 32'h0);
      rd(5'h0C, v); check("R9", v, 32'h0);
      rd(5'h04, v); check("R9", v, 32'h0000_0031);
      wr(5'h10, 32'h4); idle(2);
      rd(5'h10, v); check("R9", v, 32'h5);
      wr(5'h10, 32'h0);
      check("R9", {31'h0, irq}, 32'h0);
      rd(5'h10, v); check("R9", v, 32'h1);
      rd(5'h0C, v); check("R9", v, 32'h0000_0111);

      // R7 and R8: random traffic with interleaved clearing reads
      for (int cfg = 0; cfg < 3; cfg++) begin
         cur_req = (cfg == 1) ? "R5" : "R7";
         wr(5'h04, (cfg == 2) ? 32'h0000_000F : 32'h0000_A5A5);
         wr(5'h08, (cfg == 2) ? 32'h0000_0030 : 32'h0000_5A0F);
         wr(5'h10, (cfg == 1) ? 32'h4 : 32'h6);
         for (int c = 0; c < 1500; c++) begin
            @(negedge clk);
            din = (cfg == 2 && c[3]) ? {$urandom} | 32'h0000_000F : $urandom;
            if (c % 7 == 3) begin
               bus_rd = 1'b1; bus_addr = 5'h0C;
            end else begin
               bus_rd = 1'b0; bus_addr = 5'(($urandom % 5) * 4);
            end
         end
         @(negedge clk); bus_rd = 1'b0; bus_addr = 5'h1C;
      end

      idle(4);
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule